// File: doc/BRIEF.md
# Modem status change detector

This block watches two slow modem status lines, clear-to-send and carrier-detect, and drives one request-to-send output. Both status lines are brought into the clock domain through two flip-flops each. They are then sampled once per sample period, nominally 8 ms. The period is set as a count of system clock cycles, so any system clock from 1 MHz to 8.2 MHz gives the right spacing. Detection uses the system clock only, so it keeps working while the serial line clocks are stopped.

A new level is taken as real only when two samples in a row both show it. When reporting is enabled, each change that is taken produces one event on a valid/ready stream. The event carries the pin identity and the new level. Each pin has one pending slot. If the pin changes again before its event is taken, the slot keeps one event and updates its level to the latest one. Once an event is offered, the stream keeps offering the same pin until the consumer accepts it. The level may still be updated by the overwrite rule while it waits.

A read strobe returns a snapshot of all three pins. A write strobe sets the output.

Top module: `modem_line_watch`

## Requirements
- R1: After reset, `rts_out` is 1, `evt_valid` is 0, `rd_valid` is 0, and the taken level of both status lines is 1.
- R2: The status lines pass through two synchronising flip-flops. They are then sampled on the clock edges that end each run of `PERIOD` cycles counted from reset. The first sample falls on edge `PERIOD`.
- R3: A taken level changes only after two consecutive samples both differ from it. If only one sample differs, that deviation is discarded and produces no event.
- R4: With `rpt_en` at 1, a taken change raises `evt_valid` right after the sample edge that confirms it. `evt_pin` identifies the line (0 = clear-to-send, 1 = carrier-detect) and `evt_level` gives its new level.
- R5: With `rpt_en` at 0, taken levels still update but no event is stored.
- R6: While `evt_valid` is 1 and `evt_ready` is 0, `evt_valid` stays 1 and `evt_pin` does not change on the next cycle.
- R7: When no event is being held back, a pending clear-to-send event is offered before a pending carrier-detect event.
- R8: A second taken change on a pin whose event is still pending replaces the stored level. The pin still yields only one event.
- R9: A cycle with `rd_strobe` at 1 is followed by exactly one cycle of `rd_valid` at 1. In that cycle, `rd_cts`, `rd_cd` and `rd_rts` hold the taken levels and the output level as they were in the strobe cycle.
- R10: A cycle with `rts_wr` at 1 sets `rts_out` to `rts_wr_value` from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| cd_in | input | 1 | Carrier-detect line, asynchronous |
| rpt_en | input | 1 | Enables change events |
| rts_wr | input | 1 | Write strobe for the output pin |
| rts_wr_value | input | 1 | Level to write to the output pin |
| rts_out | output | 1 | Request-to-send output |
| rd_strobe | input | 1 | Pin-read request |
| rd_valid | output | 1 | One-cycle read response |
| rd_cts | output | 1 | Clear-to-send level in the response |
| rd_cd | output | 1 | Carrier-detect level in the response |
| rd_rts | output | 1 | Output pin level in the response |
| evt_valid | output | 1 | Change event offered |
| evt_ready | input | 1 | Consumer takes the event |
| evt_pin | output | 1 | Changed line: 0 clear-to-send, 1 carrier-detect |
| evt_level | output | 1 | New level of that line |

## Verification
The assertions check on every cycle that:
- the event stream holds its pin under back-pressure;
- a new event can appear only while reporting is enabled, and only right after a sample edge;
- the output pin follows each write;
- each read strobe gets exactly one response with the right output level.

Other behaviours need the bench's scenarios, because they depend on a history of samples rather than one clock edge:
- discarding a single-sample glitch;
- silent level updates when reporting is disabled;
- clear-to-send winning when both lines are pending;
- level overwrite in a pending slot.

// File: rtl/modem_watch_pkg.sv
package modem_watch_pkg;
  localparam int NUM_LINES = 2;
  typedef enum logic {
    LINE_CTS = 1'b0,
    LINE_CD  = 1'b1
  } line_id_e;
endpackage

// File: rtl/mw_sync2.sv
module mw_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mw_sample_tick.sv
module mw_sample_tick #(
  parameter int PERIOD = 65600
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  logic [CW-1:0] count;

  assign tick = (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= '0;
    else           count <= count + 1'b1;
  end
endmodule

// File: rtl/mw_confirm.sv
module mw_confirm #(
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sample,
  output logic level,
  output logic take
);
  logic seen_once;
  logic differs;

  assign differs = (sample != level);
  assign take    = tick & differs & seen_once;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level     <= RST_LEVEL;
      seen_once <= 1'b0;
    end else if (tick) begin
      if (take) begin
        level     <= sample;
        seen_once <= 1'b0;
      end else begin
        seen_once <= differs;
      end
    end
  end
endmodule

// File: rtl/mw_event_slot.sv
module mw_event_slot
  import modem_watch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] take,
  input  logic [NUM_LINES-1:0] new_level,
  input  logic                 rpt_en,
  output logic                 evt_valid,
  input  logic                 evt_ready,
  output logic                 evt_pin,
  output logic                 evt_level
);
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] lvl;
  logic                 held;
  logic                 held_sel;
  logic                 fire;
  line_id_e             pick;

  assign pick      = pend[LINE_CTS] ? LINE_CTS : LINE_CD;
  assign evt_valid = |pend;
  assign evt_pin   = held ? held_sel : logic'(pick);
  assign evt_level = lvl[evt_pin];
  assign fire      = evt_valid & evt_ready;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_slot
    logic clear_me;
    logic set_me;
    assign clear_me = fire & (evt_pin == 1'(i));
    assign set_me   = take[i] & rpt_en;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        lvl[i]  <= 1'b1;
      end else if (set_me) begin
        pend[i] <= 1'b1;
        lvl[i]  <= new_level[i];
      end else if (clear_me) begin
        pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_sel <= 1'b0;
    end else begin
      held     <= evt_valid & ~evt_ready;
      held_sel <= evt_pin;
    end
  end
endmodule

// File: rtl/modem_line_watch.sv
module modem_line_watch
  import modem_watch_pkg::*;
#(
  parameter int PERIOD = 65600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  input  logic cd_in,
  input  logic rpt_en,
  input  logic rts_wr,
  input  logic rts_wr_value,
  output logic rts_out,
  input  logic rd_strobe,
  output logic rd_valid,
  output logic rd_cts,
  output logic rd_cd,
  output logic rd_rts,
  output logic evt_valid,
  input  logic evt_ready,
  output logic evt_pin,
  output logic evt_level
);
  logic                 tick;
  logic [NUM_LINES-1:0] raw;
  logic [NUM_LINES-1:0] synced;
  logic [NUM_LINES-1:0] level;
  logic [NUM_LINES-1:0] take;

  assign raw[LINE_CTS] = cts_in;
  assign raw[LINE_CD]  = cd_in;

  mw_sample_tick #(.PERIOD(PERIOD)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    mw_sync2 #(.RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[i]), .q(synced[i])
    );
    mw_confirm #(.RST_LEVEL(1'b1)) u_conf (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sample(synced[i]),
      .level(level[i]), .take(take[i])
    );
  end

  mw_event_slot u_evt (
    .clk(clk), .rst_n(rst_n), .take(take), .new_level(level ^ take),
    .rpt_en(rpt_en), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_pin(evt_pin), .evt_level(evt_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rts_out <= 1'b1;
    else if (rts_wr) rts_out <= rts_wr_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_cts   <= 1'b1;
      rd_cd    <= 1'b1;
      rd_rts   <= 1'b1;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) begin
        rd_cts <= level[LINE_CTS];
        rd_cd  <= level[LINE_CD];
        rd_rts <= rts_out;
      end
    end
  end
endmodule

// File: rtl/modem_line_watch_chk.sv
module modem_line_watch_chk #(
  parameter int PERIOD = 65600
) (
  input logic clk,
  input logic rst_n,
  input logic rpt_en,
  input logic rts_wr,
  input logic rts_wr_value,
  input logic rts_out,
  input logic rd_strobe,
  input logic rd_valid,
  input logic rd_rts,
  input logic evt_valid,
  input logic evt_ready,
  input logic evt_pin
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        phase <= '0;
    else if (phase == CW'(PERIOD - 1)) phase <= '0;
    else                               phase <= phase + 1'b1;
  end

  p_hold_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_pin));

  p_event_on_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> phase == '0);

  p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> $past(rpt_en));

  p_rts_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rts_wr |=> rts_out == $past(rts_wr_value));

  p_read_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rd_valid && rd_rts == $past(rts_out));

  p_no_stray_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> !rd_valid);
endmodule

bind modem_line_watch modem_line_watch_chk #(.PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .rpt_en(rpt_en), .rts_wr(rts_wr),
  .rts_wr_value(rts_wr_value), .rts_out(rts_out), .rd_strobe(rd_strobe),
  .rd_valid(rd_valid), .rd_rts(rd_rts), .evt_valid(evt_valid),
  .evt_ready(evt_ready), .evt_pin(evt_pin)
);

// File: tb/modem_line_watch_test.sv
module modem_line_watch_test;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_in = 1'b1, cd_in = 1'b1, rpt_en = 1'b1;
  logic rts_wr = 1'b0, rts_wr_value = 1'b0, rd_strobe = 1'b0, evt_ready = 1'b1;
  logic rts_out, rd_valid, rd_cts, rd_cd, rd_rts, evt_valid, evt_pin, evt_level;

  int compared = 0;
  int mismatched = 0;
  int handshakes = 0;

  always #2 clk = ~clk;

  modem_line_watch #(.PERIOD(P)) uut (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .cd_in(cd_in), .rpt_en(rpt_en),
    .rts_wr(rts_wr), .rts_wr_value(rts_wr_value), .rts_out(rts_out),
    .rd_strobe(rd_strobe), .rd_valid(rd_valid), .rd_cts(rd_cts), .rd_cd(rd_cd),
    .rd_rts(rd_rts), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_pin(evt_pin), .evt_level(evt_level)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit s1[2], s2[2], acc[2], seen[2], pend[2], lvl[2];
  bit m_rts, m_rdv, m_rc, m_rd, m_rr, m_held, m_hsel, m_valid, m_pin;
  int cnt;
  bit ins[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        s1[i] = 1; s2[i] = 1; acc[i] = 1; seen[i] = 0; pend[i] = 0; lvl[i] = 1;
      end
      cnt = 0; m_rts = 1; m_rdv = 0; m_rc = 1; m_rd = 1; m_rr = 1;
      m_held = 0; m_hsel = 0; m_valid = 0; m_pin = 0;
    end else begin
      bit tick, fire, fpin, hold_n;
      tick = (cnt == P - 1);
      m_rdv = rd_strobe;
      if (rd_strobe) begin m_rc = acc[0]; m_rd = acc[1]; m_rr = m_rts; end
      if (m_valid && evt_ready) handshakes++;
      fire = m_valid && evt_ready;
      fpin = m_pin;
      hold_n = m_valid && !evt_ready;
      if (fire) pend[fpin] = 0;
      for (int i = 0; i < 2; i++) begin
        if (tick) begin
          if (s2[i] != acc[i]) begin
            if (seen[i]) begin
              acc[i] = s2[i]; seen[i] = 0;
              if (rpt_en) begin pend[i] = 1; lvl[i] = s2[i]; end
            end else seen[i] = 1;
          end else seen[i] = 0;
        end
      end
      ins[0] = cts_in; ins[1] = cd_in;
      for (int i = 0; i < 2; i++) begin s2[i] = s1[i]; s1[i] = ins[i]; end
      cnt = tick ? 0 : cnt + 1;
      if (rts_wr) m_rts = rts_wr_value;
      m_held = hold_n;
      m_hsel = fpin;
      m_valid = pend[0] | pend[1];
      m_pin = m_held ? m_hsel : (pend[0] ? 0 : 1);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(evt_valid == m_valid, "R4 evt_valid", evt_valid, m_valid);
      if (m_valid) begin
        check(evt_pin == m_pin, "R7 evt_pin", evt_pin, m_pin);
        check(evt_level == lvl[m_pin], "R8 evt_level", evt_level, lvl[m_pin]);
      end
      check(rts_out == m_rts, "R10 rts_out", rts_out, m_rts);
      check(rd_valid == m_rdv, "R9 rd_valid", rd_valid, m_rdv);
      if (m_rdv) begin
        check({rd_cts, rd_cd, rd_rts} == {m_rc, m_rd, m_rr}, "R9 rd_data",
              {rd_cts, rd_cd, rd_rts}, {m_rc, m_rd, m_rr});
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd_strobe = 1; cycles(1); rd_strobe = 0;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    cycles(3);
    // R1: reset state seen at the ports while reset is held
    check(rts_out == 1 && !evt_valid && !rd_valid, "R1 reset outputs",
          {rts_out, evt_valid, rd_valid}, 3'b100);
    rst_n = 1;
    do_read();
    cycles(1);
    check({rd_cts, rd_cd} == 2'b11, "R1 reset levels", {rd_cts, rd_cd}, 2'b11);

    // R2 R4: held change on clear-to-send gives one event
    cts_in = 0; cycles(20);
    check(handshakes == 1, "R4 cts event count", handshakes, 1);

    // R3: short glitch on carrier-detect is discarded
    cd_in = 0; cycles(3); cd_in = 1; cycles(20);
    check(handshakes == 1, "R3 glitch ignored", handshakes, 1);

    // R5: reporting off, level still updates
    rpt_en = 0; cts_in = 1; cycles(20);
    check(handshakes == 1 && !evt_valid, "R5 no event", handshakes, 1);
    do_read(); cycles(1);
    check(rd_cts == 1, "R5 level updated", rd_cts, 1);

    // R7 R6: both change, consumer stalls, clear-to-send first and held
    rpt_en = 1; evt_ready = 0; cts_in = 0; cd_in = 0; cycles(20);
    check(evt_valid && evt_pin == 0, "R7 cts first", evt_pin, 0);
    cycles(4);
    check(evt_valid && evt_pin == 0, "R6 held pin", evt_pin, 0);
    evt_ready = 1; cycles(4);
    check(handshakes == 3, "R7 both delivered", handshakes, 3);

    // R8: pending carrier-detect event is overwritten by a later change
    evt_ready = 0; cd_in = 1; cycles(20);
    check(evt_valid && evt_pin == 1 && evt_level == 1, "R8 first level", evt_level, 1);
    cd_in = 0; cycles(20);
    check(evt_valid && evt_pin == 1 && evt_level == 0, "R8 overwritten", evt_level, 0);
    evt_ready = 1; cycles(4);
    check(handshakes == 4 && !evt_valid, "R8 single event", handshakes, 4);

    // R10 R9: write output, read back
    rts_wr = 1; rts_wr_value = 0; cycles(1); rts_wr = 0;
    check(rts_out == 0, "R10 write low", rts_out, 0);
    do_read(); cycles(1);
    check(rd_rts == 0 && rd_cts == 0 && rd_cd == 0, "R9 snapshot",
          {rd_cts, rd_cd, rd_rts}, 0);
    rts_wr = 1; rts_wr_value = 1; cycles(1); rts_wr = 0;
    check(rts_out == 1, "R10 write high", rts_out, 1);
    cycles(5);
    report();
  end
endmodule